// File: doc/BRIEF.md
# Receive Lane Repacker (64-bit to 80-bit with byte/aux split)

This block sits on the receive side of one serial lane. Each cycle it may take in a 64-bit word from the transceiver. It treats that input as a continuous bit stream, with bit 0 of each word arriving first. It cuts the stream into 80-bit lane words: every five input words give exactly four lane words. It then splits each lane word into ten-bit groups. Each group holds one data byte in its low eight bits and two auxiliary bits in its high two bits. The bytes are presented as a 64-bit data word and the auxiliary pairs as a 16-bit side word. This undoes the interleave that the transmit side applies.

The model uses one clock. When input arrives on every cycle, a result is valid on four cycles out of every five. A wider link instantiates the block once per lane, four times in the usual arrangement, with identical copies. Searching for block or word alignment and crossing between clock domains belong to other blocks.

Top module: `lane_rx_repacker`

## Requirements
- R1: While reset is high, and on the first sample after reset is released, `out_valid` is 0 and both `out_data` and `out_aux` read zero.
- R2: After reset, the first accepted input word produces no output, because fewer than 80 bits are then held.
- R3: Input bits are packed least significant bit first. Lane word n holds stream bits 80n to 80n+79, where stream bit 64i+b is bit b of the i-th accepted input word.
- R4: For k = 0..7, `out_data[8k+7:8k]` equals bits [10k+7:10k] of the recovered 80-bit lane word.
- R5: For k = 0..7, `out_aux[2k+1:2k]` equals bits [10k+9:10k+8] of the recovered 80-bit lane word.
- R6: An output appears exactly one clock after the rising edge that accepts the input word completing it, and only then.
- R7: When input is valid on every cycle, 25 consecutive accepted words starting from an empty residue yield exactly 20 outputs, and there are never two output-less cycles in a row.
- R8: A cycle with `in_valid` low produces no output on the next cycle. It leaves the held residue unchanged, so no bit is lost or repeated.
- R9: Reset asserted in the middle of a stream discards the partial residue. The first output after reset is built only from words accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 64 | Input word from the transceiver, bit 0 first |
| out_valid | output | 1 | Output words valid |
| out_data | output | 64 | Eight recovered data bytes |
| out_aux | output | 16 | Eight recovered two-bit auxiliary fields |

## Verification
The hardest condition to reach is a stall or a reset that lands while the residue is at each of its five possible fill levels (0, 16, 32, 48, 64 bits). A lost or duplicated bit shows up only in later words. To get there, the bench builds the input with a model of the transmit interleave and feeds it with gaps driven by $urandom under a fixed seed, so stalls fall at every residue phase. It then places a reset directly after three accepted words, when 32 bits are pending, and checks that the following output is made from fresh data only.

// File: rtl/lane_rx_repacker.sv
module lane_rx_repacker #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 80
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_data,
  output logic                    out_valid,
  output logic [8*(OUT_W/10)-1:0] out_data,
  output logic [2*(OUT_W/10)-1:0] out_aux
);
  localparam int NGRP = OUT_W / 10;
  localparam int RW   = IN_W + OUT_W;
  localparam int CW   = $clog2(RW);

  logic [RW-1:0]    resid;
  logic [CW-1:0]    fill;
  logic [OUT_W-1:0] lane_word;

  wire [RW-1:0] merged = resid | ({{OUT_W{1'b0}}, in_data} << fill);
  wire [CW-1:0] total  = fill + CW'(IN_W);
  wire          full   = total >= CW'(OUT_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      resid     <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      lane_word <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (full) begin
          resid     <= merged >> OUT_W;
          fill      <= total - CW'(OUT_W);
          lane_word <= merged[OUT_W-1:0];
          out_valid <= 1'b1;
        end else begin
          resid <= merged;
          fill  <= total;
        end
      end
    end
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_split
    assign out_data[8*k +: 8] = lane_word[10*k +: 8];
    assign out_aux[2*k +: 2]  = lane_word[10*k+8 +: 2];
  end
endmodule

// File: rtl/lane_rx_repacker_chk.sv
module lane_rx_repacker_chk #(
  parameter int OUT_W = 80,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [CW-1:0] fill
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_first_word_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && in_valid |=> !out_valid);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill < CW'(OUT_W));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_cadence_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid) && !out_valid && in_valid |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(fill));
endmodule

bind lane_rx_repacker lane_rx_repacker_chk #(.OUT_W(OUT_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .fill(fill)
);

// File: tb/sim_lane_rx_repacker.sv
module sim_lane_rx_repacker;
  localparam int NFR = 1024;

  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [15:0] out_aux;

  int n_tests = 0, n_fail = 0;
  logic [63:0] fr_data [NFR];
  logic [15:0] fr_aux  [NFR];
  int  widx, acc, produced, exp_idx, ov_count;
  bit  exp_v;

  always #5 clk = ~clk;

  lane_rx_repacker u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_aux(out_aux)
  );

  function automatic logic [79:0] tx_pack(int f);
    logic [79:0] w;
    for (int k = 0; k < 8; k++) begin
      w[10*k +: 8]   = fr_data[f][8*k +: 8];
      w[10*k+8 +: 2] = fr_aux[f][2*k +: 2];
    end
    return w;
  endfunction

  function automatic logic [63:0] tx_word(int i);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) begin
      int idx = 64 * i + b;
      logic [79:0] w = tx_pack(idx / 80);
      r[b] = w[idx % 80];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, string req);
    @(negedge clk);
    check(out_valid == exp_v, req, 64'(out_valid), 64'(exp_v));
    if (out_valid) ov_count++;
    if (exp_v && out_valid) begin
      check(out_data == fr_data[exp_idx], "R4", out_data, fr_data[exp_idx]);
      check(out_aux == fr_aux[exp_idx], "R5", 64'(out_aux), 64'(fr_aux[exp_idx]));
    end
    in_valid = v;
    in_data  = v ? tx_word(widx) : {$urandom, $urandom};
    exp_v = 0;
    if (v) begin
      widx++;
      acc += 64;
      if (acc / 80 > produced) begin
        exp_v = 1;
        exp_idx = produced;
        produced++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    widx = 0; acc = 0; produced = 0; exp_v = 0;
    @(negedge clk);
    check(!out_valid && out_data == 0 && out_aux == 0, "R1",
          {out_data[62:0], out_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int f = 0; f < NFR; f++) begin
      fr_data[f] = {$urandom, $urandom};
      fr_aux[f]  = 16'($urandom);
    end
    fr_data[0] = 64'hFFFF_FFFF_FFFF_FFFF; fr_aux[0] = 16'h0000;
    fr_data[1] = 64'h0000_0000_0000_0000; fr_aux[1] = 16'hFFFF;
    do_reset();
    // R2: a single word then idle gives nothing
    step(1, "R2");
    step(0, "R2");
    step(0, "R8");
    // R7: 25 continuous words from empty residue
    do_reset();
    ov_count = 0;
    for (int i = 0; i < 25; i++) step(1, "R7");
    step(0, "R6");
    check(ov_count == 20, "R7", 64'(ov_count), 64'd20);
    // R3/R8: random stalls at every residue phase
    for (int i = 0; i < 800; i++) step(($urandom % 10) < 7, "R8");
    step(0, "R6");
    // R9: reset with 32 bits pending, then restart stream
    do_reset();
    for (int i = 0; i < 3; i++) step(1, "R9");
    do_reset();
    for (int i = 0; i < 12; i++) step(1, "R9");
    step(0, "R3");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule